// File: doc/BRIEF.md
# LIN Frame Receiver with Error Classification

This block receives frames from a single-wire LIN bus once the line has passed through an external transceiver. It finds the long dominant break that opens each frame and times the recessive delimiter that follows it. It then reads the framed bytes in order: a sync byte, a protected identifier, a fixed number of data bytes set by a parameter, and a checksum byte. Bits are sampled in the middle of each bit cell. The bit time comes from a fixed divider parameter, so the block does not measure the baud rate.

Each frame is classified as good or as carrying one or more of five error kinds: a wrong sync pattern, a delimiter that is too short, an identifier parity mismatch, a checksum mismatch, and a bad stop bit. The checksum is the enhanced form, which covers the protected identifier as well as the data. Every error kind has its own sticky flag, and software clears each flag by writing a one to its clear bit. The decoded identifier and the data bytes stay on the outputs until the next frame replaces them. A one-cycle strobe marks the end of each frame.

Top module: `lin_frame_rx`

## Requirements
- R1: A break is taken only when the synchronised line has been low for at least BREAK_BITS × BIT_DIV clock cycles and then goes high. A shorter low period is ignored, and the bytes that follow it produce neither a frame_done_o strobe nor any error flag.
- R2: If the line has been low since reset, its first rise is not a break. No frame can start until the line has been seen high at least once after reset.
- R3: The delimiter is the high time from the end of the break to the falling edge of the sync start bit. If it lasts fewer than BIT_DIV cycles, err_o bit 1 is set. A delimiter of exactly BIT_DIV cycles is accepted.
- R4: If the sync byte is not 0x55, err_o bit 0 is set.
- R5: The protected identifier carries the 6-bit ID in bits 5:0, P0 in bit 6 and P1 in bit 7, with P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5). If the received parity bits do not match, err_o bit 2 is set. id_o still receives bits 5:0, and the data bytes are still captured.
- R6: The checksum is the bitwise inverse of the 8-bit sum of the received protected identifier and all data bytes, with every carry added back in. A mismatch sets err_o bit 3. For example, ID 0x01 (protected 0xC1) with data 0x55 and checksum 0xE8 is accepted with no error.
- R7: If the stop bit of any byte in a frame is sampled low, err_o bit 4 is set. The frame is still completed.
- R8: After the checksum byte's stop bit is sampled, frame_done_o pulses high for exactly one cycle. id_o and data_o (data byte k in bits 8k+7:8k) hold their values until the next frame overwrites them. Every valid frame produces exactly one strobe.
- R9: Error flags are sticky. A one on bit k of err_clr_i clears only flag k and leaves the other flags unchanged.
- R10: Each byte is 8N1 with the LSB first, and every bit is sampled BIT_DIV/2 cycles into its cell. A low pulse shorter than half a bit is not taken as a start bit and does not disturb the frame.
- R11: After reset, id_o, data_o, err_o and frame_done_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Bus line from the transceiver, asynchronous |
| err_clr_i | input | 5 | Write-one-to-clear, one bit per error flag |
| id_o | output | 6 | Identifier of the last frame |
| data_o | output | 8*NUM_DATA | Data bytes of the last frame, byte 0 in the low bits |
| frame_done_o | output | 1 | One-cycle strobe at the end of a frame |
| err_o | output | 5 | Sticky flags: 0 sync, 1 delimiter, 2 parity, 3 checksum, 4 stop bit |

## Verification
The bench builds the block with BIT_DIV=16, BREAK_BITS=11, NUM_DATA=1 and SYNC_STAGES=2. A 16-cycle bit keeps each frame under a thousand cycles, so many frames fit in one run. It also puts the exact edges within reach: a 15-cycle delimiter against a 16-cycle one, a 10-bit break against an 11-bit one, and a 4-cycle glitch against the 8-cycle mid-bit sample point. With one data byte the bench can send the ID 0x01 / 0x55 / 0xE8 frame exactly, and a second frame checks the carry wrap in the checksum.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

   localparam int FLAG_W  = 5;
   localparam int F_SYNC  = 0;
   localparam int F_DELIM = 1;
   localparam int F_PAR   = 2;
   localparam int F_CSUM  = 3;
   localparam int F_STOP  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DELIM,
      ST_SYNC,
      ST_PID,
      ST_DATA,
      ST_CSUM
   } rx_state_e;

   // Full protected identifier for a 6-bit ID
   function automatic logic [7:0] prot_id(input logic [5:0] id);
      logic p0;
      logic p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0, id};
   endfunction

   // 8-bit add with end-around carry
   function automatic logic [7:0] add_wrap(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[7:0] + {7'd0, s[8]};
   endfunction

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   output logic line_o,
   output logic fall_o,
   output logic rise_o
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lin_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   // Reset low, so a line held low from reset never shows a falling edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], rx_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign line_o = chain[STAGES-1];
   assign fall_o = prev & ~line_o;
   assign rise_o = ~prev & line_o;

endmodule

// File: rtl/lin_rx_break.sv
module lin_rx_break #(
   parameter int BIT_DIV    = 16,
   parameter int BREAK_BITS = 11
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic rise_i,
   output logic brk_o,
   output logic short_high_o
);

   localparam int BRK_CYC = BIT_DIV * BREAK_BITS;
   localparam int LW      = $clog2(BRK_CYC + 1);
   localparam int HW      = $clog2(BIT_DIV + 1);

   logic          armed;
   logic [LW-1:0] low_cnt;
   logic [HW-1:0] high_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed    <= 1'b0;
         low_cnt  <= '0;
         high_cnt <= '0;
      end else begin
         if (line_i) begin
            armed   <= 1'b1;
            low_cnt <= '0;
            if (high_cnt != HW'(BIT_DIV)) high_cnt <= high_cnt + 1'b1;
         end else begin
            high_cnt <= '0;
            if (armed && low_cnt != LW'(BRK_CYC)) low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   // low_cnt still holds the length of the low run on the rising cycle
   assign brk_o        = rise_i && (low_cnt >= LW'(BRK_CYC));
   // high_cnt still holds the length of the high run on the falling cycle
   assign short_high_o = high_cnt < HW'(BIT_DIV);

endmodule

// File: rtl/lin_rx_byte.sv
module lin_rx_byte #(
   parameter int BIT_DIV = 16
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       line_i,
   input  logic       start_i,
   output logic       busy_o,
   output logic       valid_o,
   output logic [7:0] data_o,
   output logic       stop_bad_o
);

   localparam int HALF = BIT_DIV / 2;
   localparam int CW   = $clog2(BIT_DIV);

   logic [CW-1:0] cnt;
   logic [3:0]    idx;
   logic [7:0]    shreg;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o     <= 1'b0;
         valid_o    <= 1'b0;
         data_o     <= '0;
         stop_bad_o <= 1'b0;
         cnt        <= '0;
         idx        <= '0;
         shreg      <= '0;
      end else begin
         valid_o <= 1'b0;
         if (!busy_o) begin
            if (start_i) begin
               busy_o <= 1'b1;
               cnt    <= CW'(HALF - 1);
               idx    <= '0;
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= CW'(BIT_DIV - 1);
            idx <= idx + 4'd1;
            if (idx == 4'd0) begin
               // Start bit high at mid-cell: a glitch, drop it
               if (line_i) busy_o <= 1'b0;
            end else if (idx <= 4'd8) begin
               shreg <= {line_i, shreg[7:1]};
            end else begin
               busy_o     <= 1'b0;
               valid_o    <= 1'b1;
               data_o     <= shreg;
               stop_bad_o <= ~line_i;
            end
         end
      end
   end

endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags #(
   parameter int W = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);

   // Set beats clear when both land on the same bit in one cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o <= '0;
      else         flags_o <= (flags_o & ~clr_i) | set_i;
   end

endmodule

// File: rtl/lin_frame_rx.sv
module lin_frame_rx
   import lin_rx_pkg::*;
#(
   parameter int BIT_DIV     = 1000,
   parameter int BREAK_BITS  = 11,
   parameter int NUM_DATA    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  rx_i,
   input  logic [4:0]            err_clr_i,
   output logic [5:0]            id_o,
   output logic [8*NUM_DATA-1:0] data_o,
   output logic                  frame_done_o,
   output logic [4:0]            err_o
);

   localparam int DW = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;

   generate
      if (BIT_DIV < 4) begin : g_bad_div
         $error("lin_frame_rx: BIT_DIV must be at least 4");
      end
      if (NUM_DATA < 1 || NUM_DATA > 8) begin : g_bad_num
         $error("lin_frame_rx: NUM_DATA must be 1..8");
      end
      if (BREAK_BITS < 2) begin : g_bad_brk
         $error("lin_frame_rx: BREAK_BITS too small");
      end
   endgenerate

   logic        line_s, fall, rise;
   logic        brk, short_high;
   logic        byte_start, byte_busy, byte_valid, stop_bad;
   logic [7:0]  byte_data;
   rx_state_e   state;
   logic [DW-1:0] dcnt;
   logic [7:0]  acc;
   logic [FLAG_W-1:0] flag_set;
   logic        cap_data;
   logic [7:0]  data_r [NUM_DATA];

   lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
      .line_o(line_s), .fall_o(fall), .rise_o(rise)
   );

   lin_rx_break #(.BIT_DIV(BIT_DIV), .BREAK_BITS(BREAK_BITS)) u_break (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_s), .rise_i(rise),
      .brk_o(brk), .short_high_o(short_high)
   );

   assign byte_start = fall && !byte_busy && (state != ST_IDLE) && !brk;

   lin_rx_byte #(.BIT_DIV(BIT_DIV)) u_byte (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_s), .start_i(byte_start),
      .busy_o(byte_busy), .valid_o(byte_valid), .data_o(byte_data),
      .stop_bad_o(stop_bad)
   );

   // Error set terms for this cycle
   always_comb begin
      flag_set = '0;
      cap_data = 1'b0;
      if (state == ST_DELIM && fall && short_high) flag_set[F_DELIM] = 1'b1;
      if (byte_valid && state inside {ST_SYNC, ST_PID, ST_DATA, ST_CSUM}) begin
         if (stop_bad) flag_set[F_STOP] = 1'b1;
         case (state)
            ST_SYNC: if (byte_data != 8'h55) flag_set[F_SYNC] = 1'b1;
            ST_PID:  if (byte_data != prot_id(byte_data[5:0])) flag_set[F_PAR] = 1'b1;
            ST_DATA: cap_data = 1'b1;
            ST_CSUM: if (byte_data != ~acc) flag_set[F_CSUM] = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state        <= ST_IDLE;
         dcnt         <= '0;
         acc          <= '0;
         id_o         <= '0;
         frame_done_o <= 1'b0;
      end else begin
         frame_done_o <= 1'b0;
         if (brk) begin
            state <= ST_DELIM;
            dcnt  <= '0;
         end else begin
            case (state)
               ST_DELIM: if (fall) state <= ST_SYNC;
               ST_SYNC:  if (byte_valid) state <= ST_PID;
               ST_PID: if (byte_valid) begin
                  id_o  <= byte_data[5:0];
                  acc   <= byte_data;
                  dcnt  <= '0;
                  state <= ST_DATA;
               end
               ST_DATA: if (byte_valid) begin
                  acc <= add_wrap(acc, byte_data);
                  if (dcnt == DW'(NUM_DATA - 1)) state <= ST_CSUM;
                  else dcnt <= dcnt + 1'b1;
               end
               ST_CSUM: if (byte_valid) begin
                  frame_done_o <= 1'b1;
                  state        <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   generate
      for (genvar k = 0; k < NUM_DATA; k++) begin : g_data
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) data_r[k] <= '0;
            else if (cap_data && dcnt == DW'(k)) data_r[k] <= byte_data;
         end
         assign data_o[8*k +: 8] = data_r[k];
      end
   endgenerate

   lin_rx_flags #(.W(FLAG_W)) u_flags (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set), .clr_i(err_clr_i),
      .flags_o(err_o)
   );

endmodule

// File: rtl/lin_frame_rx_chk.sv
module lin_frame_rx_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [4:0] err_clr_i,
   input logic [4:0] err_o,
   input logic       frame_done_o,
   input logic       line_s,
   input logic       byte_valid
);

   // R8
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done_o |=> !frame_done_o);

   // R8
   done_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done_o |-> $past(byte_valid));

   // R6
   csum_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o[3]) |-> frame_done_o);

   // R7
   stop_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o[4]) |-> $past(byte_valid));

   // R3
   delim_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o[1]) |-> !$past(line_s));

   generate
      for (genvar k = 0; k < 5; k++) begin : g_sticky
         // R9
         flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(err_o[k]) && !$past(err_clr_i[k])) |-> err_o[k]);
      end
   endgenerate

endmodule

bind lin_frame_rx lin_frame_rx_chk u_chk (
   .clk_i(clk_i),
   .rst_ni(rst_ni),
   .err_clr_i(err_clr_i),
   .err_o(err_o),
   .frame_done_o(frame_done_o),
   .line_s(line_s),
   .byte_valid(byte_valid)
);

// File: tb/lin_frame_rx_bench.sv
module lin_frame_rx_bench;

   localparam int DIV = 16;
   localparam int ND  = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b0;
   logic [4:0] clr = '0;
   logic [5:0] id;
   logic [8*ND-1:0] data;
   logic       done;
   logic [4:0] err;

   int total = 0;
   int bad = 0;
   int done_cnt = 0;
   bit over = 0;

   typedef struct {
      logic [5:0] id;
      logic [7:0] data;
      logic [4:0] err;
      string      req;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   lin_frame_rx #(.BIT_DIV(DIV), .BREAK_BITS(11), .NUM_DATA(ND), .SYNC_STAGES(2)) u_lin_frame_rx (
      .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .err_clr_i(clr),
      .id_o(id), .data_o(data), .frame_done_o(done), .err_o(err)
   );

   function automatic logic [7:0] pid_calc(input logic [5:0] i);
      return {~^(i & 6'b111010), ^(i & 6'b010111), i};
   endfunction

   function automatic logic [7:0] csum_calc(input logic [7:0] p, input logic [7:0] d);
      int s;
      s = int'(p) + int'(d);
      while (s > 255) s = (s & 255) + (s >> 8);
      return ~s[7:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int cyc);
      rx = v;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic stop);
      drive(1'b0, DIV);
      for (int i = 0; i < 8; i++) drive(b[i], DIV);
      drive(stop, DIV);
      if (!stop) drive(1'b1, DIV);
   endtask

   task automatic send_frame(input int brk_bits, input int delim, input logic [7:0] syn,
                             input logic [7:0] p, input logic [7:0] d, input logic [7:0] c,
                             input logic stop_ok, input int glitch);
      drive(1'b1, 2*DIV);
      drive(1'b0, brk_bits*DIV);
      drive(1'b1, delim);
      send_byte(syn, 1'b1);
      if (glitch > 0) begin
         drive(1'b0, glitch);
         drive(1'b1, DIV);
      end
      send_byte(p, 1'b1);
      send_byte(d, stop_ok);
      send_byte(c, 1'b1);
      drive(1'b1, 3*DIV);
   endtask

   task automatic expect_frame(input logic [5:0] i, input logic [7:0] d, input logic [4:0] e,
                               input string req);
      exp_t x;
      x.id = i; x.data = d; x.err = e; x.req = req;
      q.push_back(x);
   endtask

   task automatic clear_all();
      @(negedge clk) clr = 5'h1f;
      @(negedge clk) clr = 5'h00;
   endtask

   // Scoreboard monitor
   logic done_q = 1'b0;
   always @(negedge clk) begin
      exp_t e;
      if (done_q) check("R8 strobe width", {31'd0, done}, 32'd0);
      done_q = done;
      if (done) begin
         done_cnt++;
         if (q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R8 unexpected strobe act=1 exp=0");
         end else begin
            e = q.pop_front();
            check({e.req, " id"}, {26'd0, id}, {26'd0, e.id});
            check({e.req, " data"}, {24'd0, data}, {24'd0, e.data});
            check({e.req, " flags"}, {27'd0, err}, {27'd0, e.err});
         end
      end
   end

   initial begin
      int n0;
      logic [7:0] p;
      rx = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 id", {26'd0, id}, 32'd0);
      check("R11 data", {24'd0, data}, 32'd0);
      check("R11 flags", {27'd0, err}, 32'd0);
      check("R11 strobe", {31'd0, done}, 32'd0);

      // R2 line low since reset, then a full frame body
      drive(1'b0, 30*DIV);
      check("R2 no strobe while low", done_cnt, 0);
      drive(1'b1, DIV);
      send_byte(8'h55, 1'b1);
      send_byte(8'hC1, 1'b1);
      send_byte(8'h55, 1'b1);
      send_byte(8'hE8, 1'b1);
      drive(1'b1, 3*DIV);
      check("R2 no frame after release", done_cnt, 0);
      check("R2 flags", {27'd0, err}, 32'd0);

      // R6 example frame
      expect_frame(6'h01, 8'h55, 5'b00000, "R6 example");
      send_frame(11, DIV, 8'h55, 8'hC1, 8'h55, 8'hE8, 1'b1, 0);
      clear_all();
      drive(1'b1, 20*DIV);
      check("R8 id held", {26'd0, id}, 32'h01);
      check("R8 data held", {24'd0, data}, 32'h55);

      // R6 carry wrap
      p = pid_calc(6'h3A);
      expect_frame(6'h3A, 8'hF3, 5'b00000, "R6 carry");
      send_frame(11, DIV, 8'h55, p, 8'hF3, csum_calc(p, 8'hF3), 1'b1, 0);
      clear_all();

      // R1 break one bit short
      n0 = done_cnt;
      send_frame(10, DIV, 8'h55, 8'hC1, 8'h55, 8'hE8, 1'b1, 0);
      check("R1 short break ignored", done_cnt, n0);
      check("R1 short break flags", {27'd0, err}, 32'd0);

      // R1 / R3 exact break and exact delimiter
      p = pid_calc(6'h15);
      expect_frame(6'h15, 8'hA0, 5'b00000, "R1 R3 boundary");
      send_frame(11, DIV, 8'h55, p, 8'hA0, csum_calc(p, 8'hA0), 1'b1, 0);
      clear_all();

      // R3 delimiter one cycle short
      expect_frame(6'h01, 8'h55, 5'b00010, "R3 short delim");
      send_frame(11, DIV-1, 8'h55, 8'hC1, 8'h55, 8'hE8, 1'b1, 0);
      clear_all();

      // R4 wrong sync
      expect_frame(6'h01, 8'h55, 5'b00001, "R4 bad sync");
      send_frame(11, DIV, 8'h54, 8'hC1, 8'h55, 8'hE8, 1'b1, 0);
      clear_all();

      // R5 parity flip, checksum over received byte
      expect_frame(6'h01, 8'h55, 5'b00100, "R5 parity");
      send_frame(11, DIV, 8'h55, 8'h41, 8'h55, csum_calc(8'h41, 8'h55), 1'b1, 0);
      clear_all();

      // R6 wrong checksum
      expect_frame(6'h01, 8'h55, 5'b01000, "R6 bad checksum");
      send_frame(11, DIV, 8'h55, 8'hC1, 8'h55, 8'hE9, 1'b1, 0);
      clear_all();

      // R7 low stop bit on data byte
      p = pid_calc(6'h22);
      expect_frame(6'h22, 8'h3C, 5'b10000, "R7 stop bit");
      send_frame(11, DIV, 8'h55, p, 8'h3C, csum_calc(p, 8'h3C), 1'b0, 0);
      clear_all();

      // R10 sub-half-bit glitch between bytes
      p = pid_calc(6'h07);
      expect_frame(6'h07, 8'h81, 5'b00000, "R10 glitch");
      send_frame(11, DIV, 8'h55, p, 8'h81, csum_calc(p, 8'h81), 1'b1, 4);
      clear_all();

      // R9 independent clears
      expect_frame(6'h01, 8'h55, 5'b00011, "R9 two flags");
      send_frame(11, DIV-4, 8'h54, 8'hC1, 8'h55, 8'hE8, 1'b1, 0);
      @(negedge clk) clr = 5'b00001;
      @(negedge clk) clr = 5'b00000;
      @(negedge clk);
      check("R9 clear one keeps other", {27'd0, err}, 32'b00010);
      drive(1'b1, 50);
      check("R9 sticky", {27'd0, err}, 32'b00010);
      @(negedge clk) clr = 5'b00010;
      @(negedge clk) clr = 5'b00000;
      @(negedge clk);
      check("R9 clear second", {27'd0, err}, 32'd0);

      check("R8 all frames seen", q.size(), 0);
      if (!over) begin
         over = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!over) begin
         over = 1;
         total++;
         bad++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule